// File: doc/BRIEF.md
# TLB Refill Fault Recorder

This block sits beside an address-translation lookup. It records what happened each time a translation faults, so that the handler software can refill or repair the TLB. On every fault it captures two 32-bit words. The selection word tells the handler which TLB entry to write: the entry index and the way. The cause word holds the access kind, the faulting virtual page number and the process identifier.

The block also chooses the way that a refill should replace. A miss has no matched way, so the block takes that choice from a 16-bit pseudo-random shift register. The register advances once per fault, whatever kind of fault it is. A protection fault on a hit reports the way that matched. The low two bits of the shift register are also driven out, so the lookup logic can see which way the next miss would take. TLB storage, the lookup and exception dispatch are outside this block.

Top module: `tlbf_recorder`

## Requirements
- R1: While reset is high, the block clears the selection word and the cause word and loads the shift register with 0xCCCC. The random-way output is therefore 0 after reset.
- R2: A step computes a feedback bit: the parity (XOR reduction) of the register ANDed with mask 0x8805. The register then shifts right by one, the feedback bit enters at bit 15, and the width stays 16 bits. The random-way output always equals the two low bits of the register.
- R3: The register steps exactly once in each fault cycle, for a miss and for a protection fault alike. It does not step in cycles without a fault.
- R4: For a miss (miss flag 1), selection bits 5:4 take the random-way value from before that fault's step.
- R5: For a protection fault on a hit (miss flag 0), selection bits 5:4 take the matched-way input.
- R6: For any fault, selection bits 3:0 take the low four bits of the virtual page number, and selection bits 31:6 are zero.
- R7: For any fault, the cause word holds the 19-bit virtual page number (address bits 31:13) in bits 31:13, zero in bits 12:10, the access code in bits 9:8 (0 = read, 1 = write, 2 = execute) and the 8-bit process ID in bits 7:0.
- R8: All of these updates appear on the clock edge that ends the fault-strobe cycle.
- R9: In a cycle without a fault, the selection word, the cause word and the random-way output hold their values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_i | input | 1 | Translation fault strobe, one per faulting cycle |
| miss_i | input | 1 | 1 = no entry matched, 0 = entry matched but failed protection |
| hit_way_i | input | 2 | Way of the matched entry |
| vpn_i | input | 19 | Faulting virtual page number |
| acc_i | input | 2 | Access code: 0 read, 1 write, 2 execute |
| pid_i | input | 8 | Current process ID |
| sel_o | output | 32 | Selection word: index and way for the refill |
| cause_o | output | 32 | Cause word: page, access code and process ID |
| rand_way_o | output | 2 | Way that the next miss would report |

## Verification
The selection word, the cause word and the random-way output are all registered, so each one is due at the first clock edge after the cycle in which the fault strobe is driven. Cycles without a fault must leave the same values standing after that edge. The driver applies stimulus at the falling edge and queues one expected item for every driven cycle, fault or idle. The monitor pops one item shortly after each following rising edge, so every comparison falls in exactly the cycle in which the result is due. The expected way for a miss comes from a separate shift-register model in the bench, stepped once per queued fault.

// File: rtl/tlbf_pkg.sv
package tlbf_pkg;

    localparam int WORD_W   = 32;
    localparam int VPN_W    = 19;
    localparam int IDX_W    = 4;
    localparam int WAY_W    = 2;
    localparam int PID_W    = 8;
    localparam int ACC_W    = 2;
    localparam int LFSR_W   = 16;
    localparam int CAUSE_PAD_W = WORD_W - VPN_W - ACC_W - PID_W;
    localparam int SEL_PAD_W   = WORD_W - WAY_W - IDX_W;

    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hCCCC;
    localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'h8805;

    typedef enum logic [ACC_W-1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    // Cause word: page in 31:13, pad 12:10, access 9:8, pid 7:0
    typedef struct packed {
        logic [VPN_W-1:0]       vpn;
        logic [CAUSE_PAD_W-1:0] pad;
        acc_e                   acc;
        logic [PID_W-1:0]       pid;
    } cause_t;

    // Selection word: pad 31:6, way 5:4, index 3:0
    typedef struct packed {
        logic [SEL_PAD_W-1:0] pad;
        logic [WAY_W-1:0]     way;
        logic [IDX_W-1:0]     idx;
    } sel_t;

    // Right-shifting step with parity feedback entering at the top bit
    function automatic logic [LFSR_W-1:0] lfsr_next(
        input logic [LFSR_W-1:0] cur,
        input logic [LFSR_W-1:0] taps
    );
        logic fb;
        fb = ^(cur & taps);
        return {fb, cur[LFSR_W-1:1]};
    endfunction

endpackage

// File: rtl/tlbf_rng.sv
module tlbf_rng
    import tlbf_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = LFSR_SEED,
    parameter logic [LFSR_W-1:0] TAPS = LFSR_TAPS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_i,
    output logic [LFSR_W-1:0] state_o
);

    logic [LFSR_W-1:0] state_q;
    logic [LFSR_W-1:0] tapped;
    logic [LFSR_W:0]   par_chain;

    assign tapped = state_q & TAPS;

    // Explicit parity chain over the tapped bits
    assign par_chain[0] = 1'b0;
    for (genvar b = 0; b < LFSR_W; b++) begin : g_par
        assign par_chain[b+1] = par_chain[b] ^ tapped[b];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEED;
        end else if (step_i) begin
            state_q <= {par_chain[LFSR_W], state_q[LFSR_W-1:1]};
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/tlbf_sel_build.sv
module tlbf_sel_build
    import tlbf_pkg::*;
(
    input  logic             miss_i,
    input  logic [WAY_W-1:0] rand_way_i,
    input  logic [WAY_W-1:0] hit_way_i,
    input  logic [VPN_W-1:0] vpn_i,
    output sel_t             sel_o
);

    always_comb begin
        sel_o     = '0;
        sel_o.idx = vpn_i[IDX_W-1:0];
        sel_o.way = miss_i ? rand_way_i : hit_way_i;
    end

endmodule

// File: rtl/tlbf_cause_build.sv
module tlbf_cause_build
    import tlbf_pkg::*;
(
    input  logic [VPN_W-1:0] vpn_i,
    input  logic [ACC_W-1:0] acc_i,
    input  logic [PID_W-1:0] pid_i,
    output cause_t           cause_o
);

    always_comb begin
        cause_o     = '0;
        cause_o.vpn = vpn_i;
        cause_o.acc = acc_e'(acc_i);
        cause_o.pid = pid_i;
    end

endmodule

// File: rtl/tlbf_recorder.sv
module tlbf_recorder
    import tlbf_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = LFSR_SEED,
    parameter logic [LFSR_W-1:0] TAPS = LFSR_TAPS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fault_i,
    input  logic              miss_i,
    input  logic [WAY_W-1:0]  hit_way_i,
    input  logic [VPN_W-1:0]  vpn_i,
    input  logic [ACC_W-1:0]  acc_i,
    input  logic [PID_W-1:0]  pid_i,
    output logic [WORD_W-1:0] sel_o,
    output logic [WORD_W-1:0] cause_o,
    output logic [WAY_W-1:0]  rand_way_o
);

    logic [LFSR_W-1:0] lfsr_q;
    sel_t              sel_d, sel_q;
    cause_t            cause_d, cause_q;

    tlbf_rng #(.SEED(SEED), .TAPS(TAPS)) u_rng (
        .clk     (clk),
        .rst     (rst),
        .step_i  (fault_i),
        .state_o (lfsr_q)
    );

    tlbf_sel_build u_sel (
        .miss_i     (miss_i),
        .rand_way_i (lfsr_q[WAY_W-1:0]),
        .hit_way_i  (hit_way_i),
        .vpn_i      (vpn_i),
        .sel_o      (sel_d)
    );

    tlbf_cause_build u_cause (
        .vpn_i   (vpn_i),
        .acc_i   (acc_i),
        .pid_i   (pid_i),
        .cause_o (cause_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= '0;
            cause_q <= '0;
        end else if (fault_i) begin
            sel_q   <= sel_d;
            cause_q <= cause_d;
        end
    end

    assign sel_o      = sel_q;
    assign cause_o    = cause_q;
    assign rand_way_o = lfsr_q[WAY_W-1:0];

endmodule

// File: rtl/tlbf_recorder_chk.sv
module tlbf_recorder_chk
    import tlbf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              fault_i,
    input logic              miss_i,
    input logic [WAY_W-1:0]  hit_way_i,
    input logic [VPN_W-1:0]  vpn_i,
    input logic [ACC_W-1:0]  acc_i,
    input logic [PID_W-1:0]  pid_i,
    input logic [WORD_W-1:0] sel_o,
    input logic [WORD_W-1:0] cause_o,
    input logic [WAY_W-1:0]  rand_way_o,
    input logic [LFSR_W-1:0] lfsr_q
);

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (sel_o == '0 && cause_o == '0 && lfsr_q == LFSR_SEED));

    p_shift_right_r2: assert property (@(posedge clk) disable iff (rst)
        fault_i |=> lfsr_q[LFSR_W-2:0] == $past(lfsr_q[LFSR_W-1:1]));

    p_way_tracks_reg_r2: assert property (@(posedge clk) disable iff (rst)
        rand_way_o == lfsr_q[WAY_W-1:0]);

    p_no_step_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !fault_i |=> $stable(lfsr_q));

    p_miss_way_r4: assert property (@(posedge clk) disable iff (rst)
        (fault_i && miss_i) |=> sel_o[5:4] == $past(rand_way_o));

    p_prot_way_r5: assert property (@(posedge clk) disable iff (rst)
        (fault_i && !miss_i) |=> sel_o[5:4] == $past(hit_way_i));

    p_sel_index_r6: assert property (@(posedge clk) disable iff (rst)
        fault_i |=> (sel_o[3:0] == $past(vpn_i[3:0]) && sel_o[31:6] == '0));

    p_cause_fields_r7: assert property (@(posedge clk) disable iff (rst)
        fault_i |=> (cause_o[31:13] == $past(vpn_i) && cause_o[12:10] == '0
                     && cause_o[9:8] == $past(acc_i) && cause_o[7:0] == $past(pid_i)));

    p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !fault_i |=> ($stable(sel_o) && $stable(cause_o) && $stable(rand_way_o)));

endmodule

bind tlbf_recorder tlbf_recorder_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .fault_i    (fault_i),
    .miss_i     (miss_i),
    .hit_way_i  (hit_way_i),
    .vpn_i      (vpn_i),
    .acc_i      (acc_i),
    .pid_i      (pid_i),
    .sel_o      (sel_o),
    .cause_o    (cause_o),
    .rand_way_o (rand_way_o),
    .lfsr_q     (lfsr_q)
);

// File: tb/sim_tlbf_recorder.sv
module sim_tlbf_recorder;

    typedef struct {
        logic        fault;
        logic        miss;
        logic [31:0] sel;
        logic [31:0] cause;
        logic [1:0]  way;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fault_i = 1'b0;
    logic        miss_i = 1'b0;
    logic [1:0]  hit_way_i = '0;
    logic [18:0] vpn_i = '0;
    logic [1:0]  acc_i = '0;
    logic [7:0]  pid_i = '0;
    logic [31:0] sel_o, cause_o;
    logic [1:0]  rand_way_o;

    int checks = 0;
    int errors = 0;
    exp_t q[$];

    // Bench model state
    logic [15:0] m_lfsr = 16'hCCCC;
    logic [31:0] m_sel = '0;
    logic [31:0] m_cause = '0;

    always #5 clk = ~clk;

    tlbf_recorder u0 (
        .clk(clk), .rst(rst), .fault_i(fault_i), .miss_i(miss_i),
        .hit_way_i(hit_way_i), .vpn_i(vpn_i), .acc_i(acc_i), .pid_i(pid_i),
        .sel_o(sel_o), .cause_o(cause_o), .rand_way_o(rand_way_o)
    );

    function automatic logic [15:0] model_step(input logic [15:0] s);
        logic fb;
        fb = s[15] ^ s[11] ^ s[2] ^ s[0];
        return {fb, s[15:1]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus, pushes the expected item
    task automatic drive(input logic f, input logic m, input logic [1:0] hw,
                         input logic [18:0] vpn, input logic [1:0] acc, input logic [7:0] pid);
        exp_t e;
        logic [1:0] way;
        @(negedge clk);
        fault_i = f; miss_i = m; hit_way_i = hw; vpn_i = vpn; acc_i = acc; pid_i = pid;
        if (f) begin
            way     = m ? m_lfsr[1:0] : hw;
            m_sel   = {26'b0, way, vpn[3:0]};
            m_cause = {vpn, 3'b000, acc, pid};
            m_lfsr  = model_step(m_lfsr);
        end
        e.fault = f; e.miss = m; e.sel = m_sel; e.cause = m_cause; e.way = m_lfsr[1:0];
        q.push_back(e);
    endtask

    // Monitor: result is due at the rising edge after the driven cycle
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                if (!e.fault) begin
                    check("R9 hold sel", sel_o, e.sel);
                    check("R9 hold cause", cause_o, e.cause);
                    check("R3 no step idle", {30'b0, rand_way_o}, {30'b0, e.way});
                end else begin
                    check(e.miss ? "R4 miss way" : "R5 matched way",
                          {30'b0, sel_o[5:4]}, {30'b0, e.sel[5:4]});
                    check("R6 index and pad", {sel_o[31:6], sel_o[3:0]}, {e.sel[31:6], e.sel[3:0]});
                    check("R7 R8 cause word", cause_o, e.cause);
                    check("R2 R3 step per fault", {30'b0, rand_way_o}, {30'b0, e.way});
                end
            end
        end
    end

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 sel reset", sel_o, 32'h0);
        check("R1 cause reset", cause_o, 32'h0);
        check("R1 seed low bits", {30'b0, rand_way_o}, 32'h0);

        // Directed cases
        drive(1, 1, 2'd3, 19'h12345, 2'd0, 8'h5A);   // miss, read
        drive(0, 0, 2'd1, 19'h7FFFF, 2'd2, 8'hFF);   // idle with busy inputs (R9)
        drive(1, 0, 2'd3, 19'h7FFFF, 2'd1, 8'hFF);   // protection on write, all-ones page
        drive(1, 0, 2'd2, 19'h00000, 2'd2, 8'h00);   // protection on exec, zero page
        drive(0, 1, 2'd0, 19'h0AAAA, 2'd1, 8'h11);   // idle
        drive(0, 0, 2'd3, 19'h05555, 2'd2, 8'h22);   // idle
        // R2: a long run of back-to-back misses walks the register
        for (int i = 0; i < 24; i++)
            drive(1, 1, 2'd0, 19'(i * 16 + 15), 2'(i % 3), 8'(i * 7));
        // Mixed pseudo-random traffic
        for (int i = 0; i < 80; i++)
            drive(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
                  19'($urandom), 2'($urandom_range(0, 2)), 8'($urandom));
        drive(0, 0, 2'd0, 19'h0, 2'd0, 8'h0);
        while (q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule